// File: doc/BRIEF.md
# Two-Way FIFO Write-Back Data Cache

This block is a small data cache that sits between a requester issuing 8-byte loads and stores and a backing memory that moves whole 16-byte lines. It holds 64 bytes as two sets of two ways. Every access is answered with the data word and a flag saying whether it was found in the cache.

Stores stay in the cache and mark the line dirty. A store that misses first brings the line in and then merges its word into it. When a set is full, the way that was filled earliest leaves first. Hits do not reorder the ways. A dirty line that leaves is written out to memory as a whole line. Only after that write does the read of the new line start.

A controller steps through five named states. IDLE accepts a request. COMPARE looks the address up and goes to RESPOND on a hit, to WRITEBACK on a miss with a dirty victim, or to FILL on a miss with a clean or empty victim. WRITEBACK waits for the memory to take the victim line and then goes to FILL. FILL waits for the new line and then goes to RESPOND. RESPOND presents the answer for one cycle and returns to IDLE.

Top module: `two_way_fifo_cache`

## Requirements
- R1: The byte address splits as follows. Bits [3:0] are the offset, and bit 3 picks word 0 or word 1 of the line. Bit 4 is the set. The bits above 4 are the tag. mem_addr carries the byte address shifted right by 4, so two accesses that differ only in bits [3:0] fall in the same line.
- R2: A load returns the latest value stored at that address, whether it hits or misses. A store returns the word it wrote on resp_rdata.
- R3: On a miss in a set whose two ways are both valid, the victim is the way filled earliest in that set. Hits never change this order.
- R4: An invalid way is filled before any valid way is evicted. In an empty set, way 0 is filled first and way 1 second.
- R5: A store hit changes only the cache and marks the line dirty. No memory transaction is issued between the request and its response.
- R6: A store miss reports resp_hit=0. It reads the whole line from memory, merges the store word into it, and leaves the line dirty.
- R7: A dirty victim is written to memory as a full line (mem_write=1) at the victim's own line address. In the cycle after that write is accepted, the fill read (mem_write=0) is presented.
- R8: A miss with a clean or invalid victim issues exactly one line read and no memory write.
- R9: req_ready is high only in IDLE, with no memory request or response active. Each accepted request gets exactly one response pulse on resp_valid, one cycle long.
- R10: While mem_valid is high and mem_ready is low, mem_addr, mem_write and mem_wdata hold their values.
- R11: Reset clears every valid bit, dirty bit and FIFO pointer. After reset the outputs are idle and the first access to any line misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Cache can accept a request (IDLE) |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Byte address of the 8-byte word |
| req_wdata | input | WORD_W | Store data |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_hit | output | 1 | 1 = access hit, 0 = miss |
| resp_rdata | output | WORD_W | Load data, or the stored word for a store |
| mem_valid | output | 1 | Memory line request active |
| mem_ready | input | 1 | Memory completes the request this cycle |
| mem_write | output | 1 | 1 = line writeback, 0 = line fill read |
| mem_addr | output | ADDR_W-4 | Line address |
| mem_wdata | output | LINE_W | Victim line for a writeback |
| mem_rdata | input | LINE_W | Fill line, valid with mem_ready on a read |

## Verification
Two things can happen on the same clock edge. The first is a store miss: the fill line arrives, the store word is merged into it, and the line is marked dirty, all at once. The second is a dirty eviction, where the writeback is accepted and the fill read for the new line is presented on the next edge. A directed sequence sets up both cases. It dirties a line, then sends a store miss to a different tag in the same set while that dirty line is the oldest. A bench model follows valid, tag, dirty and fill order per set, and the memory answers with random delays. The bench judges the result by the writeback's address and contents, the number of writes and reads per access, and a later miss on the evicted line, which must bring back the merged store word.

// File: rtl/wb2_cache_pkg.sv
package wb2_cache_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMP,
        ST_WB,
        ST_FILL,
        ST_RESP
    } ctl_state_t;
endpackage

// File: rtl/wb2_line_store.sv
// Tag, state and data arrays for every set and way, plus one fill-order bit per set.
module wb2_line_store #(
    parameter int TAG_W    = 11,
    parameter int LINE_W   = 128,
    parameter int NUM_SETS = 2,
    parameter int SET_W    = 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [SET_W-1:0]            look_set,
    output logic [1:0]                  way_valid,
    output logic [1:0]                  way_dirty,
    output logic [1:0][TAG_W-1:0]       way_tag,
    output logic [1:0][LINE_W-1:0]      way_line,
    output logic                        fifo_ptr,
    output logic [NUM_SETS-1:0]         fifo_ptrs,
    input  logic                        upd_en,
    input  logic                        upd_way,
    input  logic [TAG_W-1:0]            upd_tag,
    input  logic [LINE_W-1:0]           upd_line,
    input  logic                        upd_dirty,
    input  logic                        upd_is_fill
);
    logic [NUM_SETS-1:0][1:0]              valid_q;
    logic [NUM_SETS-1:0][1:0]              dirty_q;
    logic [NUM_SETS-1:0][1:0][TAG_W-1:0]   tag_q;
    logic [NUM_SETS-1:0][1:0][LINE_W-1:0]  data_q;
    logic [NUM_SETS-1:0]                   ptr_q;

    for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
        logic set_hit;
        assign set_hit = upd_en && (look_set == SET_W'(s));

        // Each fill advances the set's oldest-way pointer.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ptr_q[s] <= 1'b0;
            end else if (set_hit && upd_is_fill) begin
                ptr_q[s] <= ~ptr_q[s];
            end
        end

        for (genvar w = 0; w < 2; w++) begin : g_way
            logic sel;
            assign sel = set_hit && (upd_way == w[0]);

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    valid_q[s][w] <= 1'b0;
                    dirty_q[s][w] <= 1'b0;
                end else if (sel) begin
                    valid_q[s][w] <= 1'b1;
                    dirty_q[s][w] <= upd_dirty;
                end
            end

            always_ff @(posedge clk) begin
                if (sel) begin
                    tag_q[s][w]  <= upd_tag;
                    data_q[s][w] <= upd_line;
                end
            end
        end
    end

    always_comb begin
        way_valid = valid_q[look_set];
        way_dirty = dirty_q[look_set];
        way_tag   = tag_q[look_set];
        way_line  = data_q[look_set];
        fifo_ptr  = ptr_q[look_set];
        fifo_ptrs = ptr_q;
    end
endmodule

// File: rtl/wb2_way_pick.sv
// Tag compare and victim choice for one set.
module wb2_way_pick #(
    parameter int TAG_W = 11
) (
    input  logic [1:0]            way_valid,
    input  logic [1:0][TAG_W-1:0] way_tag,
    input  logic [TAG_W-1:0]      look_tag,
    input  logic                  fifo_ptr,
    output logic                  hit,
    output logic                  hit_way,
    output logic                  victim_way
);
    logic [1:0] match;

    for (genvar w = 0; w < 2; w++) begin : g_cmp
        assign match[w] = way_valid[w] && (way_tag[w] == look_tag);
    end

    always_comb begin
        hit     = |match;
        hit_way = match[1];
        // Empty ways go first. Otherwise take the earliest-filled way.
        if (!way_valid[0]) begin
            victim_way = 1'b0;
        end else if (!way_valid[1]) begin
            victim_way = 1'b1;
        end else begin
            victim_way = fifo_ptr;
        end
    end
endmodule

// File: rtl/wb2_miss_fsm.sv
// Controller: accept, compare, optional writeback, fill, respond.
module wb2_miss_fsm
    import wb2_cache_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       look_hit,
    input  logic       vic_dirty,
    input  logic       mem_ready,
    output ctl_state_t state,
    output logic       req_ready,
    output logic       accept,
    output logic       cmp_en,
    output logic       hit_upd,
    output logic       fill_done,
    output logic       mem_valid,
    output logic       mem_write,
    output logic       resp_valid
);
    ctl_state_t state_d;

    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE: if (req_valid) state_d = ST_CMP;
            ST_CMP: begin
                if (look_hit)       state_d = ST_RESP;
                else if (vic_dirty) state_d = ST_WB;
                else                state_d = ST_FILL;
            end
            ST_WB:   if (mem_ready) state_d = ST_FILL;
            ST_FILL: if (mem_ready) state_d = ST_RESP;
            ST_RESP: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    always_comb begin
        req_ready  = 1'b0;
        accept     = 1'b0;
        cmp_en     = 1'b0;
        hit_upd    = 1'b0;
        fill_done  = 1'b0;
        mem_valid  = 1'b0;
        mem_write  = 1'b0;
        resp_valid = 1'b0;
        unique case (state)
            ST_IDLE: begin
                req_ready = 1'b1;
                accept    = req_valid;
            end
            ST_CMP: begin
                cmp_en  = 1'b1;
                hit_upd = look_hit;
            end
            ST_WB: begin
                mem_valid = 1'b1;
                mem_write = 1'b1;
            end
            ST_FILL: begin
                mem_valid = 1'b1;
                fill_done = mem_ready;
            end
            ST_RESP: resp_valid = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/two_way_fifo_cache.sv
module two_way_fifo_cache
    import wb2_cache_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int WORD_W     = 64,
    parameter int LINE_WORDS = 2,
    parameter int NUM_SETS   = 2,
    localparam int LINE_W    = WORD_W * LINE_WORDS,
    localparam int OFF_W     = $clog2((WORD_W / 8) * LINE_WORDS),
    localparam int LADDR_W   = ADDR_W - OFF_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [WORD_W-1:0]  req_wdata,
    output logic               resp_valid,
    output logic               resp_hit,
    output logic [WORD_W-1:0]  resp_rdata,
    output logic               mem_valid,
    input  logic               mem_ready,
    output logic               mem_write,
    output logic [LADDR_W-1:0] mem_addr,
    output logic [LINE_W-1:0]  mem_wdata,
    input  logic [LINE_W-1:0]  mem_rdata
);
    localparam int SEL_W = $clog2(LINE_WORDS);
    localparam int SET_W = $clog2(NUM_SETS);
    localparam int TAG_W = LADDR_W - SET_W;

    ctl_state_t state;
    logic accept, cmp_en, hit_upd, fill_done;

    logic              wr_q;
    logic [ADDR_W-1:0] addr_q;
    logic [WORD_W-1:0] wdata_q;
    logic              vic_q;
    logic              hit_q;
    logic [WORD_W-1:0] rdata_q;

    logic [SET_W-1:0]  look_set;
    logic [TAG_W-1:0]  look_tag;
    logic [SEL_W-1:0]  word_sel;

    logic [1:0]               way_valid, way_dirty;
    logic [1:0][TAG_W-1:0]    way_tag;
    logic [1:0][LINE_W-1:0]   way_line;
    logic                     fifo_ptr;
    logic [NUM_SETS-1:0]      fifo_ptrs;
    logic                     look_hit, hit_way, victim_way, vic_dirty;

    logic [LINE_W-1:0] base_line, merged_line;
    logic              upd_en, upd_way, upd_dirty;

    assign look_set = addr_q[OFF_W +: SET_W];
    assign look_tag = addr_q[ADDR_W-1 -: TAG_W];
    assign word_sel = addr_q[OFF_W-1 -: SEL_W];

    always_ff @(posedge clk) begin
        if (accept) begin
            wr_q    <= req_write;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    wb2_line_store #(
        .TAG_W(TAG_W), .LINE_W(LINE_W), .NUM_SETS(NUM_SETS), .SET_W(SET_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .look_set(look_set),
        .way_valid(way_valid), .way_dirty(way_dirty), .way_tag(way_tag),
        .way_line(way_line), .fifo_ptr(fifo_ptr), .fifo_ptrs(fifo_ptrs),
        .upd_en(upd_en), .upd_way(upd_way), .upd_tag(look_tag),
        .upd_line(merged_line), .upd_dirty(upd_dirty), .upd_is_fill(fill_done)
    );

    wb2_way_pick #(.TAG_W(TAG_W)) u_pick (
        .way_valid(way_valid), .way_tag(way_tag), .look_tag(look_tag),
        .fifo_ptr(fifo_ptr), .hit(look_hit), .hit_way(hit_way),
        .victim_way(victim_way)
    );

    assign vic_dirty = way_valid[victim_way] && way_dirty[victim_way];

    wb2_miss_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .look_hit(look_hit),
        .vic_dirty(vic_dirty), .mem_ready(mem_ready), .state(state),
        .req_ready(req_ready), .accept(accept), .cmp_en(cmp_en),
        .hit_upd(hit_upd), .fill_done(fill_done), .mem_valid(mem_valid),
        .mem_write(mem_write), .resp_valid(resp_valid)
    );

    // Lock in the victim during compare so that writeback and fill work on the same way.
    always_ff @(posedge clk) begin
        if (cmp_en) vic_q <= victim_way;
    end

    always_comb begin
        if (state == ST_WB) mem_addr = {way_tag[vic_q], look_set};
        else                mem_addr = {look_tag, look_set};
        mem_wdata = way_line[vic_q];
    end

    // A store's word goes into the hit line, or into the fill line as it arrives.
    always_comb begin
        base_line   = fill_done ? mem_rdata : way_line[hit_way];
        merged_line = base_line;
        if (wr_q) merged_line[int'(word_sel) * WORD_W +: WORD_W] = wdata_q;
    end

    assign upd_en    = fill_done || (hit_upd && wr_q);
    assign upd_way   = fill_done ? vic_q : hit_way;
    assign upd_dirty = wr_q;

    always_ff @(posedge clk) begin
        if (hit_upd || fill_done) begin
            rdata_q <= merged_line[int'(word_sel) * WORD_W +: WORD_W];
            hit_q   <= hit_upd;
        end
    end

    assign resp_hit   = hit_q;
    assign resp_rdata = rdata_q;
endmodule

// File: rtl/wb2_cache_chk.sv
module wb2_cache_chk
    import wb2_cache_pkg::*;
#(
    parameter int LADDR_W  = 12,
    parameter int LINE_W   = 128,
    parameter int NUM_SETS = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_ready,
    input logic               resp_valid,
    input logic               mem_valid,
    input logic               mem_ready,
    input logic               mem_write,
    input logic [LADDR_W-1:0] mem_addr,
    input logic [LINE_W-1:0]  mem_wdata,
    input ctl_state_t         state,
    input logic               look_hit,
    input logic               fill_done,
    input logic [NUM_SETS-1:0] fifo_ptrs
);
    a_r10_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)
                                       && $stable(mem_write) && $stable(mem_wdata)));

    a_r7_wb_then_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_write && mem_ready) |=> (mem_valid && !mem_write));

    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    a_r9_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mem_valid && !resp_valid));

    a_r5_hit_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CMP && look_hit) |=> (!mem_valid && resp_valid));

    a_r3_order_on_fill_only: assert property (@(posedge clk) disable iff (!rst_n)
        !fill_done |=> $stable(fifo_ptrs));
endmodule

bind two_way_fifo_cache wb2_cache_chk #(
    .LADDR_W(LADDR_W), .LINE_W(LINE_W), .NUM_SETS(NUM_SETS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .resp_valid(resp_valid),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .state(state),
    .look_hit(look_hit), .fill_done(fill_done), .fifo_ptrs(fifo_ptrs)
);

// File: tb/tb_two_way_fifo_cache.sv
module tb_two_way_fifo_cache;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic         req_write = 1'b0;
    logic [15:0]  req_addr = '0;
    logic [63:0]  req_wdata = '0;
    logic         resp_valid, resp_hit;
    logic [63:0]  resp_rdata;
    logic         mem_valid, mem_write;
    logic         mem_ready = 1'b0;
    logic [11:0]  mem_addr;
    logic [127:0] mem_wdata;
    logic [127:0] mem_rdata = '0;

    int n_total = 0;
    int n_fail  = 0;
    int cyc     = 0;

    two_way_fifo_cache dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_rdata(resp_rdata),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Backing memory: 16 lines, answering after 0 to 2 extra cycles.
    logic [127:0] memarr [16];
    logic [127:0] gmem   [16];
    int           wb_cnt = 0, fill_cnt = 0, lat = 0;
    logic [11:0]  wb_addr, p_addr;
    logic [127:0] wb_data;
    bit           pend = 0, p_wr;

    always @(negedge clk) begin
        if (mem_ready) begin
            mem_ready = 1'b0;
        end else if (mem_valid) begin
            if (!pend) begin
                pend = 1; p_addr = mem_addr; p_wr = mem_write; lat = $urandom % 3;
            end
            if (lat == 0) begin
                chk(mem_addr == p_addr && mem_write == p_wr, "R10",
                    "memory request held", {115'b0, mem_write, mem_addr},
                    {115'b0, p_wr, p_addr});
                pend = 0;
                mem_ready = 1'b1;
                if (mem_write) begin
                    memarr[mem_addr[3:0]] = mem_wdata;
                    wb_cnt++; wb_addr = mem_addr; wb_data = mem_wdata;
                end else begin
                    mem_rdata = memarr[mem_addr[3:0]];
                    fill_cnt++;
                end
            end else begin
                lat--;
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_total++; n_fail++;
            $display("FAIL R9 watchdog: actual %0d cycles expected < 150000", cyc);
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    // Reference model: one valid, tag and dirty bit per way, one fill-order bit per set.
    bit       mv [2][2];
    bit       md [2][2];
    bit [2:0] mt [2][2];
    bit       mp [2];

    // exp_dir: 0 = must miss, 1 = must hit, 2 = whatever the model says.
    task automatic access(input bit wr, input logic [7:0] a, input logic [63:0] wd,
                          input int exp_dir, input string tag);
        bit s = a[4];
        bit [2:0] tg = a[7:5];
        bit hit = 0, hw = 0, v = 0, exp_wb = 0, tw;
        logic [3:0]   wb_line = '0;
        logic [127:0] wb_exp = '0;
        logic [63:0]  exp_rd;
        int wb0 = wb_cnt, fl0 = fill_cnt, k;
        for (int w = 0; w < 2; w++)
            if (mv[s][w] && mt[s][w] == tg) begin hit = 1; hw = w[0]; end
        if (!hit) begin
            v = !mv[s][0] ? 1'b0 : (!mv[s][1] ? 1'b1 : mp[s]);
            exp_wb = mv[s][v] && md[s][v];
            wb_line = {mt[s][v], s};
            wb_exp = gmem[wb_line];
            mv[s][v] = 1; mt[s][v] = tg; md[s][v] = 0; mp[s] = ~mp[s];
            tw = v;
        end else begin
            tw = hw;
        end
        if (wr) md[s][tw] = 1;
        exp_rd = wr ? wd : gmem[a[7:4]][a[3]*64 +: 64];
        if (wr) gmem[a[7:4]][a[3]*64 +: 64] = wd;

        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = {8'h00, a}; req_wdata = wd;
        @(negedge clk);
        req_valid = 0;
        k = 0;
        while (!resp_valid && k < 60) begin @(negedge clk); k++; end
        chk(resp_valid, "R9", {tag, " response seen"}, 128'(resp_valid), 128'(1));
        chk(resp_hit == hit, "R3", {tag, " hit/miss vs fill order"}, 128'(resp_hit), 128'(hit));
        if (exp_dir != 2)
            chk(resp_hit == exp_dir[0], "R4", {tag, " directed hit flag"},
                128'(resp_hit), 128'(exp_dir));
        chk(resp_rdata == exp_rd, "R2", {tag, " data word"}, 128'(resp_rdata), 128'(exp_rd));
        chk(fill_cnt - fl0 == (hit ? 0 : 1), "R8", {tag, " fill reads"},
            128'(fill_cnt - fl0), 128'(hit ? 0 : 1));
        chk(wb_cnt - wb0 == int'(exp_wb), "R7", {tag, " writebacks"},
            128'(wb_cnt - wb0), 128'(exp_wb));
        if (exp_wb && wb_cnt != wb0) begin
            chk(wb_addr == {8'h00, wb_line}, "R1", {tag, " writeback line address"},
                128'(wb_addr), 128'(wb_line));
            chk(wb_data == wb_exp, "R7", {tag, " writeback line data"}, wb_data, wb_exp);
        end
        @(negedge clk);
        chk(!resp_valid, "R9", {tag, " single response pulse"}, 128'(resp_valid), 128'(0));
    endtask

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < 16; i++) begin
            memarr[i] = {$urandom, $urandom, $urandom, $urandom};
            gmem[i]   = memarr[i];
        end
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11: outputs are idle after reset.
        chk(req_ready && !resp_valid && !mem_valid, "R11", "idle after reset",
            {125'b0, req_ready, resp_valid, mem_valid}, 128'b100);

        // Directed: set 0 only, tags 0,1,2,3 = addresses 0x00,0x20,0x40,0x60.
        access(0, 8'h00, '0, 0, "R11 first access misses");
        access(0, 8'h20, '0, 0, "R4 second way filled");
        access(0, 8'h08, '0, 1, "R1 other word same line");
        access(0, 8'h00, '0, 1, "R3 hit keeps order");
        access(0, 8'h40, '0, 0, "R3 oldest evicted");
        access(0, 8'h00, '0, 0, "R3 evicted line misses");
        access(1, 8'h48, 64'hC0FFEE0012345678, 1, "R5 store hit");
        access(1, 8'h60, 64'hDEAD0000BEEF1111, 0, "R6 R7 store miss dirty victim");
        access(0, 8'h68, '0, 1, "R6 other word of allocated line");
        access(0, 8'h60, '0, 1, "R6 merged word");
        access(0, 8'h48, '0, 0, "R7 written-back word returns");
        access(0, 8'h10, '0, 0, "R4 set 1 independent");

        // Random mix over 16 lines.
        for (int i = 0; i < 400; i++) begin
            logic [7:0] ra = {$urandom % 16, $urandom % 2 == 1, 3'b000};
            access($urandom % 2 == 1, ra, {$urandom, $urandom}, 2, "random");
        end

        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end
endmodule